// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block collects single-cycle event pulses from a bus bridge into a 32-bit status register, qualifies them with a per-bit mask register and a global enable bit, and drives one level-sensitive interrupt line to the processor. Software reaches the three registers over a simple local bus. Status bits clear when a one is written to them, and an event that arrives in the same cycle as its own clear is never lost.

Only eleven status positions are built. The positions are fixed because software decodes them:
- bits 0 to 3: inbound-descriptor completion, success, failure and end-of-list
- bits 4 to 7: the same four events for outbound descriptors
- bit 9: inbound out-of-descriptors
- bit 25: the external device interrupt line
- bit 26: a bus abort

The block also reports the index of the lowest-numbered pending source, so an interrupt handler can pick that source without scanning the register.

Top module: `irq_status_agg`

## Requirements
- R1: A one on `evt_in[k]` at a rising clock edge sets status bit k when k is an implemented position. The bit then stays set until software clears it.
- R2: A write to offset 0x500 clears every status bit whose write-data bit is one. Status bits whose write-data bit is zero keep their value.
- R3: When an event and a clearing write hit the same status bit in the same cycle, the bit is set after that edge.
- R4: The implemented status and mask positions form the mask 0x060002FF. Every other position reads as zero, and events or writes to those positions have no effect.
- R5: The mask register sits at offset 0x504 and reads back what was written, limited to the implemented positions. The pending vector is the status ANDed with the mask.
- R6: Bit 0 of the register at offset 0x508 is the global enable, and it reads back in bit 0. While it is 0, `irq_out` is low whatever the status and mask hold.
- R7: `irq_out` is high exactly while the global enable is 1 and the pending vector is non-zero. It falls once the last pending bit is cleared or masked.
- R8: `pend_idx` gives the lowest set position of the pending vector. `pend_valid` is high only when the pending vector is non-zero. Both are independent of the global enable.
- R9: After reset, the status, mask and enable registers read zero, and `irq_out` and `pend_valid` are low.
- R10: A read from any offset other than 0x500, 0x504 and 0x508 returns zero. `bus_rdata` is combinational from the address in the cycle that `bus_sel` is high and `bus_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no register is read |
| evt_in | input | 32 | Event pulses, one per status position |
| irq_out | output | 1 | Level interrupt to the processor |
| pend_valid | output | 1 | Some unmasked status bit is set |
| pend_idx | output | 5 | Lowest pending position |

## Verification
The hardest case to reach from the ports is a status bit that is cleared and set in the same edge. The bench starts an event pulse and a clearing write to that bit in the same low clock phase, so both are seen at one rising edge. It then reads the bit back.

Walking the pending index upward means clearing the lower sources one group at a time and then narrowing the mask. Each step is checked before the next write, so the lowest-index priority is seen at bits 0, 4, 25 and 26.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int unsigned STAT_W = 32;
  parameter int unsigned IDX_W  = $clog2(STAT_W);

  // implemented status positions: descriptor events 0..7, 9, external line 25, abort 26
  parameter logic [STAT_W-1:0] IMPL_BITS = 32'h0600_02FF;

  parameter logic [11:0] OFF_STATUS = 12'h500;
  parameter logic [11:0] OFF_MASK   = 12'h504;
  parameter logic [11:0] OFF_GEN    = 12'h508;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_GEN    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_data,
  input  logic [STAT_W-1:0] evt,
  output logic [STAT_W-1:0] status_q
);
  logic [STAT_W-1:0] set_v;
  logic [STAT_W-1:0] clr_v;
  logic [STAT_W-1:0] status_d;
  logic              status_en;

  always_comb begin
    set_v     = evt & IMPL_BITS;
    clr_v     = clr_wr ? (clr_data & IMPL_BITS) : '0;
    // a set in the same cycle wins over the clear
    status_d  = ((status_q & ~clr_v) | set_v) & IMPL_BITS;
    status_en = clr_wr | (|set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              gen_wr,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] mask_q,
  output logic              gen_en_q
);
  logic [STAT_W-1:0] mask_d;
  logic              gen_en_d;

  always_comb begin
    mask_d   = wdata & IMPL_BITS;
    gen_en_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gen_en_q <= 1'b0;
    else if (gen_wr) gen_en_q <= gen_en_d;
  end
endmodule

// File: rtl/irq_low_enc.sv
module irq_low_enc #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          valid
);
  always_comb begin
    idx   = '0;
    valid = |vec;
    // scan downward so the lowest set position is the last one taken
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [STAT_W-1:0] bus_rdata,
  input  logic [STAT_W-1:0] evt_in,
  output logic              irq_out,
  output logic              pend_valid,
  output logic [IDX_W-1:0]  pend_idx
);
  logic              rst_sync_n;
  reg_sel_e          reg_sel;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] mask_q;
  logic              gen_en_q;
  logic [STAT_W-1:0] pend_vec;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    reg_sel = SEL_NONE;
    if (bus_sel) begin
      if (bus_addr == ADDR_W'(OFF_STATUS))    reg_sel = SEL_STATUS;
      else if (bus_addr == ADDR_W'(OFF_MASK)) reg_sel = SEL_MASK;
      else if (bus_addr == ADDR_W'(OFF_GEN))  reg_sel = SEL_GEN;
    end
  end

  irq_status_reg u_stat (
    .clk(clk), .rst_n(rst_sync_n),
    .clr_wr(bus_wr && reg_sel == SEL_STATUS),
    .clr_data(bus_wdata), .evt(evt_in), .status_q(status_q)
  );

  irq_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .mask_wr(bus_wr && reg_sel == SEL_MASK),
    .gen_wr(bus_wr && reg_sel == SEL_GEN),
    .wdata(bus_wdata), .mask_q(mask_q), .gen_en_q(gen_en_q)
  );

  assign pend_vec = status_q & mask_q;

  irq_low_enc #(.W(STAT_W), .IW(IDX_W)) u_enc (
    .vec(pend_vec), .idx(pend_idx), .valid(pend_valid)
  );

  assign irq_out = gen_en_q & pend_valid;

  always_comb begin
    bus_rdata = '0;
    if (!bus_wr) begin
      unique case (reg_sel)
        SEL_STATUS: bus_rdata = status_q;
        SEL_MASK:   bus_rdata = mask_q;
        SEL_GEN:    bus_rdata = {{(STAT_W-1){1'b0}}, gen_en_q};
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [STAT_W-1:0] bus_wdata,
  input logic [STAT_W-1:0] bus_rdata,
  input logic [STAT_W-1:0] evt_in,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] mask_q,
  input logic              gen_en_q,
  input logic              irq_out,
  input logic              pend_valid,
  input logic [IDX_W-1:0]  pend_idx
);
  logic st_wr;
  assign st_wr = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_STATUS);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    st_wr |=> ((status_q & $past(bus_wdata) & ~$past(evt_in)) == '0));

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(evt_in & IMPL_BITS)) |=> ((status_q & $past(evt_in & IMPL_BITS)) == $past(evt_in & IMPL_BITS)));

  a_r4_read_impl: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr) |-> ((bus_rdata & ~IMPL_BITS) == '0 || bus_addr == ADDR_W'(OFF_GEN)));

  a_r6_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !gen_en_q |-> !irq_out);

  a_r7_level: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gen_en_q && pend_valid) |-> irq_out);

  a_r8_idx_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_valid |-> (status_q[pend_idx] && mask_q[pend_idx]));

  a_r8_idx_lowest: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_valid |-> ((status_q & mask_q & ((32'd1 << pend_idx) - 32'd1)) == '0));

  a_r8_none: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pend_valid |-> ((status_q & mask_q) == '0));
endmodule

bind irq_status_agg irq_status_agg_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .evt_in(evt_in), .status_q(status_q), .mask_q(mask_q), .gen_en_q(gen_en_q),
  .irq_out(irq_out), .pend_valid(pend_valid), .pend_idx(pend_idx)
);

// File: tb/irq_status_agg_tb_top.sv
`timescale 1ns/1ps
module irq_status_agg_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] evt_in;
  logic        irq_out;
  logic        pend_valid;
  logic [4:0]  pend_idx;

  irq_status_agg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq_out(irq_out), .pend_valid(pend_valid),
    .pend_idx(pend_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // kind: 0 = read data, 1 = irq_out, 2 = {pend_valid, pend_idx}
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  event      sample_ev;
  int        checks = 0;
  int        errors = 0;
  bit        done   = 0;

  // monitor: pops expectations and compares them against the ports
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_item_t it;
        logic [31:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          0:       act = bus_rdata;
          1:       act = {31'd0, irq_out};
          default: act = {26'd0, pend_valid, pend_idx};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic bus_op(input logic wr, input logic [11:0] a,
                        input logic [31:0] d, input logic [31:0] ev);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; evt_in = ev;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; evt_in = '0;
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk);
    evt_in = ev;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic exp_read(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    exp_q.push_back('{0, e, tag});
    -> sample_ev;
    #1;
    bus_sel = 1'b0;
  endtask

  task automatic exp_out(input int kind, input logic [31:0] e, input string tag);
    @(negedge clk);
    #1;
    exp_q.push_back('{kind, e, tag});
    -> sample_ev;
    #1;
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    exp_read(12'h500, 32'h0, "R9 status after reset");
    exp_read(12'h504, 32'h0, "R9 mask after reset");
    exp_read(12'h508, 32'h0, "R9 enable after reset");
    exp_out(1, 32'h0, "R9 irq after reset");
    exp_out(2, 32'h0, "R9 pend_valid after reset");

    // R1 R4 latch all, only implemented bits stay
    pulse(32'hFFFF_FFFF);
    exp_read(12'h500, 32'h0600_02FF, "R1 R4 status after all events");
    exp_out(1, 32'h0, "R6 irq low while disabled");
    exp_out(2, 32'h0, "R5 nothing pending with mask zero");

    // R5 mask readback and pending
    bus_op(1'b1, 12'h504, 32'hFFFF_FFFF, '0);
    exp_read(12'h504, 32'h0600_02FF, "R5 R4 mask readback");
    exp_out(2, {26'd0, 1'b1, 5'd0}, "R8 lowest index 0");
    exp_out(1, 32'h0, "R6 irq gated by enable");

    // R6 R7 enable
    bus_op(1'b1, 12'h508, 32'hFFFF_FFFF, '0);
    exp_read(12'h508, 32'h1, "R6 enable readback");
    exp_out(1, 32'h1, "R7 irq high");

    // R2 clear low nibble
    bus_op(1'b1, 12'h500, 32'h0000_000F, '0);
    exp_read(12'h500, 32'h0600_02F0, "R2 cleared bits 0-3");
    exp_out(2, {26'd0, 1'b1, 5'd4}, "R8 lowest index 4");
    bus_op(1'b1, 12'h500, 32'h0, '0);
    exp_read(12'h500, 32'h0600_02F0, "R2 zero write keeps status");

    // R3 clear and event on bit 4 in one cycle
    bus_op(1'b1, 12'h500, 32'h0000_0010, 32'h0000_0010);
    exp_read(12'h500, 32'h0600_02F0, "R3 set wins over clear");

    bus_op(1'b1, 12'h500, 32'h0000_02F0, '0);
    exp_read(12'h500, 32'h0600_0000, "R2 cleared descriptor bits");
    exp_out(2, {26'd0, 1'b1, 5'd25}, "R8 lowest index 25");
    bus_op(1'b1, 12'h504, 32'h0400_0000, '0);
    exp_out(2, {26'd0, 1'b1, 5'd26}, "R8 R5 mask narrows to 26");
    exp_out(1, 32'h1, "R7 irq still high");

    // R6 R8 disable keeps pending
    bus_op(1'b1, 12'h508, 32'h0, '0);
    exp_out(1, 32'h0, "R6 irq low after disable");
    exp_out(2, {26'd0, 1'b1, 5'd26}, "R8 pending without enable");

    // R10 undecoded read
    exp_read(12'h50C, 32'h0, "R10 undecoded offset");
    exp_read(12'h000, 32'h0, "R10 offset zero");

    // R7 falls after last clear
    bus_op(1'b1, 12'h508, 32'h1, '0);
    exp_out(1, 32'h1, "R7 irq back high");
    bus_op(1'b1, 12'h500, 32'hFFFF_FFFF, '0);
    exp_out(1, 32'h0, "R7 irq low after clear all");
    exp_out(2, 32'h0, "R8 nothing pending");

    // R4 unimplemented event ignored
    pulse(32'h0000_0100);
    exp_read(12'h500, 32'h0, "R4 bit 8 event ignored");
    exp_out(1, 32'h0, "R4 irq unaffected");

    // R1 hold over idle cycles
    pulse(32'h0000_0200);
    repeat (10) @(negedge clk);
    exp_read(12'h500, 32'h0000_0200, "R1 bit 9 held");

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule